// File: doc/BRIEF.md
# Register-ALU Execute Datapath

This block is the execute half of a 32-bit processor that completes one instruction per clock. It holds a 32-entry register file, an immediate widener, an ALU and a small word memory. The fetch stage and the decoder sit outside it. Each cycle they present an instruction word and a set of decoded steering signals. The block then computes a result and returns a Zero flag, which the fetch stage uses to resolve conditional branches.

All state changes on one rising clock edge: the register write and the memory store. Reads from the register file and from the memory are combinational. A value written in one cycle is therefore seen by the instruction in the next cycle. The ALU result and the value headed for the register file are also brought out as ports, so the surrounding pipeline logic and a test bench can observe them.

Top module: `exec_datapath`

## Requirements
- R1: Source register addresses come from fixed instruction bits: the first source from bits 25:21 and the second from bits 20:16. The immediate is bits 15:0.
- R2: Register 0 always reads as zero. A write aimed at register 0 leaves it zero.
- R3: With `dst_sel_rd` low the write lands in the register named by bits 20:16. With it high the write lands in the register named by bits 15:11.
- R4: With `ext_signed` low the immediate's upper 16 bits are zero. With it high they copy immediate bit 15.
- R5: With `opb_imm` low the ALU second operand is the second source register. With it high it is the widened immediate.
- R6: `alu_op` encodings: 2'b00 adds, 2'b01 subtracts the second operand from the first, 2'b10 is bitwise OR, 2'b11 yields zero.
- R7: With `wb_from_mem` low `wb_data` is the ALU result. With it high it is the memory word read at the ALU-result address. The register file takes `wb_data` on the edge when `reg_write` is high.
- R8: With `mem_write` high, the second source register value is stored on the clock edge. The store goes to word `alu_result[9:2]` of a 256-word memory. Memory reads are asynchronous.
- R9: `zero_flag` is high exactly when `alu_result` is all zeros. Subtracting a register from itself therefore raises it.
- R10: While `rst_n` is low every register clears to zero and no memory store occurs. The memory keeps its contents across reset.
- R11: Register reads in a cycle see the value from before that cycle's write. A written value appears from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the register file |
| instr | input | 32 | Current instruction word |
| reg_write | input | 1 | Enable register file write |
| dst_sel_rd | input | 1 | Destination field select (0: bits 20:16, 1: bits 15:11) |
| ext_signed | input | 1 | Immediate widening (0: zero fill, 1: sign fill) |
| opb_imm | input | 1 | ALU second operand select (0: register, 1: immediate) |
| alu_op | input | 2 | ALU operation code |
| mem_write | input | 1 | Enable memory store |
| wb_from_mem | input | 1 | Write-back source (0: ALU, 1: memory) |
| alu_result | output | 32 | ALU output, also the memory address |
| wb_data | output | 32 | Value offered to the register file |
| zero_flag | output | 1 | High when the ALU output is zero |

## Verification
A corrupted register or memory word stays hidden until an instruction reads it. It then shows up combinationally that same cycle on `alu_result`, `zero_flag` or `wb_data`. A wrong write address or a missed write is caught at the first later read of that register, usually one cycle after the write. Fault latency is bounded by how soon the stimulus reads state back. For that reason the random phase reads source registers drawn from the whole file, and every memory word is first given a known value.

// File: rtl/exec_datapath.sv
module exec_datapath #(
  parameter int MEM_AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] instr,
  input  logic        reg_write,
  input  logic        dst_sel_rd,
  input  logic        ext_signed,
  input  logic        opb_imm,
  input  logic [1:0]  alu_op,
  input  logic        mem_write,
  input  logic        wb_from_mem,
  output logic [31:0] alu_result,
  output logic [31:0] wb_data,
  output logic        zero_flag
);
  localparam int NREGS = 32;
  localparam int MEM_WORDS = 1 << MEM_AW;

  logic [31:0] rf   [NREGS];
  logic [31:0] dmem [MEM_WORDS];

  logic [4:0]  src_a, src_b, dst;
  logic [31:0] bus_a, bus_b, imm_w, opnd_b, mem_rd;
  logic [MEM_AW-1:0] widx;

  assign src_a  = instr[25:21];
  assign src_b  = instr[20:16];
  assign dst    = dst_sel_rd ? instr[15:11] : instr[20:16];
  assign bus_a  = (src_a == 5'd0) ? 32'd0 : rf[src_a];
  assign bus_b  = (src_b == 5'd0) ? 32'd0 : rf[src_b];
  assign imm_w  = {ext_signed ? {16{instr[15]}} : 16'h0000, instr[15:0]};
  assign opnd_b = opb_imm ? imm_w : bus_b;

  always_comb begin
    case (alu_op)
      2'b00:   alu_result = bus_a + opnd_b;
      2'b01:   alu_result = bus_a - opnd_b;
      2'b10:   alu_result = bus_a | opnd_b;
      default: alu_result = 32'd0;
    endcase
  end

  assign zero_flag = ~|alu_result;
  assign widx      = alu_result[MEM_AW+1:2];
  assign mem_rd    = dmem[widx];
  assign wb_data   = wb_from_mem ? mem_rd : alu_result;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= 32'd0;
    end else if (reg_write && dst != 5'd0) begin
      rf[dst] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && mem_write) dmem[widx] <= bus_b;
  end

  assert_sub_self_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 2'b01 && !opb_imm && src_a == src_b) |-> zero_flag);

  assert_x0_stays_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == 5'd0 && alu_op == 2'b10 && !opb_imm && src_b == 5'd0) |-> alu_result == 32'd0);

  assert_write_visible_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_write) && $past(dst) != 5'd0 && src_a == $past(dst))
      |-> bus_a == $past(wb_data));

  assert_store_then_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mem_write) && wb_from_mem && widx == $past(widx))
      |-> wb_data == $past(bus_b));

  assert_sign_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == 5'd0 && opb_imm && alu_op == 2'b00)
      |-> alu_result[31:16] == (ext_signed ? {16{instr[15]}} : 16'h0000));
endmodule

// File: tb/exec_datapath_test.sv
`timescale 1ns/1ps
module exec_datapath_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr;
  logic        reg_write, dst_sel_rd, ext_signed, opb_imm, mem_write, wb_from_mem;
  logic [1:0]  alu_op;
  logic [31:0] alu_result, wb_data;
  logic        zero_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_rf  [32];
  logic [31:0] m_mem [256];

  exec_datapath uut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .reg_write(reg_write),
    .dst_sel_rd(dst_sel_rd), .ext_signed(ext_signed), .opb_imm(opb_imm),
    .alu_op(alu_op), .mem_write(mem_write), .wb_from_mem(wb_from_mem),
    .alu_result(alu_result), .wb_data(wb_data), .zero_flag(zero_flag));

  always #5 clk = ~clk;

  function automatic logic [31:0] itype(input int rs, input int rt, input logic [15:0] imm);
    return {6'h08, rs[4:0], rt[4:0], imm};
  endfunction

  function automatic logic [31:0] rtype(input int rs, input int rt, input int rd);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 11'h000};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] ins, input bit rw, input bit sel_rd, input bit sx,
                      input bit bimm, input logic [1:0] op, input bit mw, input bit mfm,
                      input string tag);
    logic [31:0] a, b, imm, ob, res, wb;
    int d;
    instr = ins; reg_write = rw; dst_sel_rd = sel_rd; ext_signed = sx;
    opb_imm = bimm; alu_op = op; mem_write = mw; wb_from_mem = mfm;
    a   = m_rf[ins[25:21]];
    b   = m_rf[ins[20:16]];
    imm = sx ? 32'(signed'(ins[15:0])) : {16'h0, ins[15:0]};
    ob  = bimm ? imm : b;
    if (op == 2'b00) res = a + ob;
    else if (op == 2'b01) res = a - ob;
    else if (op == 2'b10) res = a | ob;
    else res = 32'd0;
    wb = mfm ? m_mem[res[9:2]] : res;
    d  = sel_rd ? int'(ins[15:11]) : int'(ins[20:16]);
    #1;
    check(tag, "alu_result", alu_result, res);
    check(tag, "wb_data", wb_data, wb);
    check(tag, "zero_flag", {31'd0, zero_flag}, {31'd0, (res == 32'd0)});
    @(posedge clk);
    if (rw && d != 0) m_rf[d] = wb;
    if (mw) m_mem[res[9:2]] = b;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    rst_n = 1'b0; instr = 32'd0; reg_write = 0; dst_sel_rd = 0; ext_signed = 0;
    opb_imm = 0; alu_op = 2'b00; mem_write = 0; wb_from_mem = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: registers cleared after reset
    step(rtype(5, 9, 0), 0, 0, 0, 0, 2'b10, 0, 0, "R10 reset state");
    // R4 zero fill, R3 rt destination, R5 immediate operand
    step(itype(0, 1, 16'h8001), 1, 0, 0, 1, 2'b10, 0, 0, "R4 zero-extend");
    step(itype(1, 2, 16'h0000), 1, 0, 0, 1, 2'b00, 0, 0, "R3 rt dest");
    // R4 sign fill
    step(itype(0, 3, 16'h8001), 1, 0, 1, 1, 2'b00, 0, 0, "R4 sign-extend");
    // R3 rd destination, R6 add, R5 register operand
    step(rtype(1, 3, 4), 1, 1, 0, 0, 2'b00, 0, 0, "R6 add R3 rd dest");
    step(rtype(4, 1, 5), 1, 1, 0, 0, 2'b01, 0, 0, "R6 sub");
    step(rtype(5, 3, 6), 1, 1, 0, 0, 2'b10, 0, 0, "R6 or");
    step(rtype(6, 3, 7), 0, 1, 0, 0, 2'b11, 0, 0, "R6 code 11");
    // R9 self subtract
    step(rtype(3, 3, 0), 0, 1, 0, 0, 2'b01, 0, 0, "R9 self-sub zero");
    step(rtype(3, 1, 0), 0, 1, 0, 0, 2'b01, 0, 0, "R9 nonzero");
    // R2 write to register 0 ignored
    step(itype(3, 0, 16'h0000), 1, 0, 0, 1, 2'b00, 0, 0, "R2 write x0");
    step(rtype(0, 0, 0), 0, 1, 0, 0, 2'b10, 0, 0, "R2 read x0");
    // R11 write visible only next cycle
    step(itype(7, 7, 16'h0005), 1, 0, 0, 1, 2'b10, 0, 0, "R11 same cycle");
    step(itype(7, 8, 16'h0000), 1, 0, 0, 1, 2'b10, 0, 0, "R11 next cycle");
    // R8 give every memory word a known value, R1 address fields
    for (int i = 0; i < 256; i++)
      step(itype(0, (i % 8), 16'(i * 4)), 0, 0, 0, 1, 2'b00, 1, 0, "R8 store");
    // R7 load through write-back
    step(itype(0, 9, 16'h0008), 1, 0, 0, 1, 2'b00, 0, 1, "R7 load");
    step(itype(0, 3, 16'h0400), 0, 0, 0, 1, 2'b00, 1, 0, "R8 wrap store");
    step(itype(0, 10, 16'h0000), 1, 0, 0, 1, 2'b00, 0, 1, "R8 wrap load");
    // random mix: R1 R5 R6 R7 R8 R9
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      step({6'h0, r[25:0]}, r[26], r[27], r[28], r[29], 2'($urandom_range(0, 3)),
           ($urandom_range(0, 3) == 0), r[30], "R1 R6 R7 random");
    end
    // R10 mid-run reset clears registers, memory kept
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    step(rtype(4, 6, 0), 0, 1, 0, 0, 2'b10, 0, 0, "R10 regs cleared");
    step(itype(0, 11, 16'h0010), 1, 0, 0, 1, 2'b00, 0, 1, "R10 mem kept");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule